// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block holds the hazard control for a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory access and writeback. The block is purely combinational. Each cycle it looks at the register numbers and flags held in the pipeline registers, and at the branch outcome from the equality comparator in decode. From these it drives several controls: the operand bypass selects for the execute stage, the operand bypass selects for the decode-stage branch comparator, the hold enables for the program counter and the fetch/decode register, a bubble into the decode/execute register, and a squash of the fetch/decode register.

Branches resolve at the end of decode, so a branch costs at most one cycle. A two-bit policy input chooses how that cycle is handled. The first choice holds fetch and drops the slot. The second keeps fetching down the sequential path and squashes the fetched instruction when the branch is taken. The third lets the instruction after the branch always execute. A load result exists only after the memory stage, so any use of it in the very next instruction costs a one-cycle hold. A branch whose operands are still being produced waits in decode until they can be bypassed into the comparator.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each execute operand select is independent and picks the memory-stage result (code 2'b10) over the writeback-stage result (2'b01) over the register file (2'b00). Code 2'b11 never appears.
- R2: A stage's destination matches a source only when that stage's write flag is 1 and its destination is non-zero. Register 0 is never bypassed.
- R3: When the instruction in execute is a load with the write flag set and a non-zero destination equal to either decode source, pc_hold, ifid_hold and idex_bubble are all 1 and ifid_flush is 0.
- R4: When decode holds a branch, the same three holds are raised in two cases: any writing instruction in execute targets one of the branch sources, or a load in the memory stage targets one of them.
- R5: Each branch comparator select is 2'b10 for a matching memory-stage non-load writer, otherwise 2'b01 for a matching writeback-stage writer, otherwise 2'b00.
- R6: With policy 2'b00 or 2'b11 (hold), a branch in decode that is not stalled gives ifid_flush=1 and pc_hold equal to the inverse of the taken input. ifid_hold and idex_bubble are 0.
- R7: With policy 2'b01 (predict not taken), a branch in decode that is not stalled gives ifid_flush equal to the taken input, and no hold.
- R8: With policy 2'b10 (delay slot), a branch raises neither a hold nor a flush.
- R9: A stall always wins. Whenever a hold from R3 or R4 is raised, ifid_flush is 0 whatever the taken input and the policy.
- R10: With no load-use, no branch dependency and no branch in decode, all four flow controls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | 5 | First source register of the instruction in decode |
| id_src_b | input | 5 | Second source register of the instruction in decode |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_br_taken | input | 1 | Comparator says the branch is taken |
| ex_src_a | input | 5 | First source register of the instruction in execute |
| ex_src_b | input | 5 | Second source register of the instruction in execute |
| ex_dst | input | 5 | Destination held in the decode/execute register |
| ex_wr | input | 1 | Register-write flag of the decode/execute register |
| ex_is_load | input | 1 | Instruction in execute reads memory |
| mem_dst | input | 5 | Destination held in the execute/memory register |
| mem_wr | input | 1 | Register-write flag of the execute/memory register |
| mem_is_load | input | 1 | Instruction in memory stage is a load |
| wb_dst | input | 5 | Destination held in the memory/writeback register |
| wb_wr | input | 1 | Register-write flag of the memory/writeback register |
| br_policy | input | 2 | Branch policy: 00/11 hold, 01 predict, 10 delay slot |
| ex_sel_a | output | 2 | Execute operand A bypass select |
| ex_sel_b | output | 2 | Execute operand B bypass select |
| br_sel_a | output | 2 | Branch comparator operand A bypass select |
| br_sel_b | output | 2 | Branch comparator operand B bypass select |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| ifid_flush | output | 1 | Replace the fetch/decode contents with a no-op |

## Verification
The interesting collision is a branch sitting in decode with a taken outcome while a stall condition is active in the same cycle. Under every policy the stall must win and the squash must stay low. The bench provokes this directly by presenting a taken branch together with a load in execute, and together with a writer in execute, that targets a branch source. The random phase uses a register range of only four numbers, so load-use, branch dependency and taken branches overlap often under all four policy codes. Every output is compared each clock against a behavioural model, so a wrong priority shows up as a flush or hold mismatch tagged R9 or R6/R7.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
   typedef enum logic [1:0] {
      SEL_REGFILE = 2'b00,
      SEL_WB      = 2'b01,
      SEL_MEM     = 2'b10
   } byp_sel_e;

   typedef enum logic [1:0] {
      POL_HOLD    = 2'b00,
      POL_PREDICT = 2'b01,
      POL_DELAY   = 2'b10,
      POL_HOLD2   = 2'b11
   } br_policy_e;

   localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hzu_fwd_pick.sv
module hzu_fwd_pick
   import hzu_pkg::*;
#(
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] near_dst,
   input  logic              near_wr,
   input  logic              near_ready,
   input  logic [REG_AW-1:0] far_dst,
   input  logic              far_wr,
   output logic [1:0]        sel
);
   logic near_live;
   logic far_live;
   logic near_hit;
   logic far_hit;

   generate
      if (ZERO_FIXED) begin : g_zero_fixed
         assign near_live = near_wr && (near_dst != '0);
         assign far_live  = far_wr  && (far_dst  != '0);
      end else begin : g_zero_plain
         assign near_live = near_wr;
         assign far_live  = far_wr;
      end
   endgenerate

   assign near_hit = near_live && near_ready && (near_dst == src);
   assign far_hit  = far_live && (far_dst == src);

   always_comb begin
      if (near_hit)     sel = SEL_MEM;
      else if (far_hit) sel = SEL_WB;
      else              sel = SEL_REGFILE;
   end

   always_comb begin
      assert_sel_legal_R1: assert ($onehot0(sel));
      if (ZERO_FIXED && src == '0)
         assert_no_zero_bypass_R2: assert (sel == SEL_REGFILE);
   end
endmodule

// File: rtl/hzu_stall_detect.sv
module hzu_stall_detect
   import hzu_pkg::*;
#(
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] id_src_a,
   input  logic [REG_AW-1:0] id_src_b,
   input  logic              id_is_branch,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_wr,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wr,
   input  logic              mem_is_load,
   output logic              load_use,
   output logic              br_wait,
   output logic              stall
);
   logic [REG_AW-1:0]  srcs [NUM_SRC];
   logic [NUM_SRC-1:0] ex_hit;
   logic [NUM_SRC-1:0] mem_hit;
   logic               ex_live;
   logic               mem_live;

   assign srcs[0] = id_src_a;
   assign srcs[1] = id_src_b;

   generate
      if (ZERO_FIXED) begin : g_zero_fixed
         assign ex_live  = ex_wr  && (ex_dst  != '0);
         assign mem_live = mem_wr && (mem_dst != '0);
      end else begin : g_zero_plain
         assign ex_live  = ex_wr;
         assign mem_live = mem_wr;
      end

      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign ex_hit[i]  = ex_live  && (ex_dst  == srcs[i]);
         assign mem_hit[i] = mem_live && (mem_dst == srcs[i]);
      end
   endgenerate

   assign load_use = ex_is_load && (|ex_hit);
   assign br_wait  = id_is_branch && ((|ex_hit) || (mem_is_load && (|mem_hit)));
   assign stall    = load_use || br_wait;

   always_comb begin
      if (!id_is_branch)
         assert_nonbranch_wait_R4: assert (!br_wait);
   end
endmodule

// File: rtl/hzu_flow_ctrl.sv
module hzu_flow_ctrl
   import hzu_pkg::*;
(
   input  logic       stall,
   input  logic       id_is_branch,
   input  logic       id_br_taken,
   input  logic [1:0] br_policy,
   output logic       pc_hold,
   output logic       ifid_hold,
   output logic       idex_bubble,
   output logic       ifid_flush
);
   br_policy_e pol;
   logic       resolved;

   assign pol      = br_policy_e'(br_policy);
   assign resolved = id_is_branch && !stall;

   always_comb begin
      pc_hold     = 1'b0;
      ifid_hold   = 1'b0;
      idex_bubble = 1'b0;
      ifid_flush  = 1'b0;
      if (stall) begin
         pc_hold     = 1'b1;
         ifid_hold   = 1'b1;
         idex_bubble = 1'b1;
      end else if (resolved) begin
         unique case (pol)
            POL_PREDICT: ifid_flush = id_br_taken;
            POL_DELAY:   ifid_flush = 1'b0;
            default: begin
               ifid_flush = 1'b1;
               pc_hold    = !id_br_taken;
            end
         endcase
      end
   end

   always_comb begin
      if (stall)
         assert_stall_beats_flush_R9: assert (!ifid_flush);
      if (pol == POL_DELAY)
         assert_delay_no_flush_R8: assert (!ifid_flush);
      if (!id_is_branch && !stall)
         assert_quiet_when_idle_R10: assert (!pc_hold && !ifid_flush);
   end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
   import hzu_pkg::*;
#(
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_FIXED = 1'b1
) (
   input  logic [REG_AW-1:0] id_src_a,
   input  logic [REG_AW-1:0] id_src_b,
   input  logic              id_is_branch,
   input  logic              id_br_taken,
   input  logic [REG_AW-1:0] ex_src_a,
   input  logic [REG_AW-1:0] ex_src_b,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_wr,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wr,
   input  logic              mem_is_load,
   input  logic [REG_AW-1:0] wb_dst,
   input  logic              wb_wr,
   input  logic [1:0]        br_policy,
   output logic [1:0]        ex_sel_a,
   output logic [1:0]        ex_sel_b,
   output logic [1:0]        br_sel_a,
   output logic [1:0]        br_sel_b,
   output logic              pc_hold,
   output logic              ifid_hold,
   output logic              idex_bubble,
   output logic              ifid_flush
);
   localparam int unsigned MAX_AW = 8;

   generate
      if (REG_AW < 1 || REG_AW > MAX_AW) begin : g_bad_aw
         $error("pipe_hazard_ctrl: REG_AW out of range");
      end
   endgenerate

   logic [REG_AW-1:0] ex_srcs [NUM_SRC];
   logic [REG_AW-1:0] id_srcs [NUM_SRC];
   logic [1:0]        ex_sel  [NUM_SRC];
   logic [1:0]        br_sel  [NUM_SRC];
   logic              load_use;
   logic              br_wait;
   logic              stall;

   assign ex_srcs[0] = ex_src_a;
   assign ex_srcs[1] = ex_src_b;
   assign id_srcs[0] = id_src_a;
   assign id_srcs[1] = id_src_b;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
         hzu_fwd_pick #(.REG_AW(REG_AW), .ZERO_FIXED(ZERO_FIXED)) u_ex_pick (
            .src        (ex_srcs[i]),
            .near_dst   (mem_dst),
            .near_wr    (mem_wr),
            .near_ready (1'b1),
            .far_dst    (wb_dst),
            .far_wr     (wb_wr),
            .sel        (ex_sel[i])
         );
         hzu_fwd_pick #(.REG_AW(REG_AW), .ZERO_FIXED(ZERO_FIXED)) u_br_pick (
            .src        (id_srcs[i]),
            .near_dst   (mem_dst),
            .near_wr    (mem_wr),
            .near_ready (!mem_is_load),
            .far_dst    (wb_dst),
            .far_wr     (wb_wr),
            .sel        (br_sel[i])
         );
      end
   endgenerate

   assign ex_sel_a = ex_sel[0];
   assign ex_sel_b = ex_sel[1];
   assign br_sel_a = br_sel[0];
   assign br_sel_b = br_sel[1];

   hzu_stall_detect #(.REG_AW(REG_AW), .ZERO_FIXED(ZERO_FIXED)) u_stall (
      .id_src_a     (id_src_a),
      .id_src_b     (id_src_b),
      .id_is_branch (id_is_branch),
      .ex_dst       (ex_dst),
      .ex_wr        (ex_wr),
      .ex_is_load   (ex_is_load),
      .mem_dst      (mem_dst),
      .mem_wr       (mem_wr),
      .mem_is_load  (mem_is_load),
      .load_use     (load_use),
      .br_wait      (br_wait),
      .stall        (stall)
   );

   hzu_flow_ctrl u_flow (
      .stall        (stall),
      .id_is_branch (id_is_branch),
      .id_br_taken  (id_br_taken),
      .br_policy    (br_policy),
      .pc_hold      (pc_hold),
      .ifid_hold    (ifid_hold),
      .idex_bubble  (idex_bubble),
      .ifid_flush   (ifid_flush)
   );

   always_comb begin
      if (ifid_hold)
         assert_hold_set_R3: assert (pc_hold && idex_bubble && !ifid_flush);
      if (load_use)
         assert_loaduse_holds_R3: assert (ifid_hold);
      if (br_wait)
         assert_branch_waits_R4: assert (ifid_hold && !ifid_flush);
   end
endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 5;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [AW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
   logic id_is_branch, id_br_taken, ex_wr, ex_is_load, mem_wr, mem_is_load, wb_wr;
   logic [1:0] br_policy;
   logic [1:0] ex_sel_a, ex_sel_b, br_sel_a, br_sel_b;
   logic pc_hold, ifid_hold, idex_bubble, ifid_flush;

   int n_cmp  = 0;
   int n_fail = 0;

   pipe_hazard_ctrl #(.REG_AW(AW)) u_pipe_hazard_ctrl (
      .id_src_a(id_src_a), .id_src_b(id_src_b), .id_is_branch(id_is_branch),
      .id_br_taken(id_br_taken), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
      .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_is_load(ex_is_load),
      .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_is_load(mem_is_load),
      .wb_dst(wb_dst), .wb_wr(wb_wr), .br_policy(br_policy),
      .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .br_sel_a(br_sel_a), .br_sel_b(br_sel_b),
      .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
      .ifid_flush(ifid_flush)
   );

   // Behavioural model: which earlier instruction owns a register value.
   function automatic int model_sel(int src, int m_dst, bit m_wr, bit m_ok, int w_dst, bit w_wr);
      if (src == 0) return 0;                       // R2: register 0 never bypassed
      if (m_wr && m_ok && m_dst == src) return 2;   // R1 / R5: youngest producer first
      if (w_wr && w_dst == src) return 1;
      return 0;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int  e_ea, e_eb, e_ba, e_bb;
      bit  lu, bw, stl;
      int  e_pc, e_ifh, e_bub, e_fl;
      string ftag;
      e_ea = model_sel(ex_src_a, mem_dst, mem_wr, 1'b1, wb_dst, wb_wr);
      e_eb = model_sel(ex_src_b, mem_dst, mem_wr, 1'b1, wb_dst, wb_wr);
      e_ba = model_sel(id_src_a, mem_dst, mem_wr, !mem_is_load, wb_dst, wb_wr);
      e_bb = model_sel(id_src_b, mem_dst, mem_wr, !mem_is_load, wb_dst, wb_wr);
      lu = ex_is_load && ex_wr && ex_dst != 0 && (ex_dst == id_src_a || ex_dst == id_src_b);
      bw = id_is_branch && (
             (ex_wr && ex_dst != 0 && (ex_dst == id_src_a || ex_dst == id_src_b)) ||
             (mem_is_load && mem_wr && mem_dst != 0 && (mem_dst == id_src_a || mem_dst == id_src_b)));
      stl = lu || bw;
      e_pc = 0; e_ifh = 0; e_bub = 0; e_fl = 0;
      if (stl) begin
         e_pc = 1; e_ifh = 1; e_bub = 1; ftag = "R9";
      end else if (id_is_branch) begin
         case (br_policy)
            2'b01: begin e_fl = id_br_taken; ftag = "R7"; end
            2'b10: begin ftag = "R8"; end
            default: begin e_fl = 1; e_pc = !id_br_taken; ftag = "R6"; end
         endcase
      end else ftag = "R10";
      check("R1/R2", "ex_sel_a", ex_sel_a, e_ea);
      check("R1/R2", "ex_sel_b", ex_sel_b, e_eb);
      check("R5", "br_sel_a", br_sel_a, e_ba);
      check("R5", "br_sel_b", br_sel_b, e_bb);
      check(stl ? (lu ? "R3" : "R4") : ftag, "pc_hold", pc_hold, e_pc);
      check(stl ? (lu ? "R3" : "R4") : ftag, "ifid_hold", ifid_hold, e_ifh);
      check(stl ? (lu ? "R3" : "R4") : ftag, "idex_bubble", idex_bubble, e_bub);
      check(ftag, "ifid_flush", ifid_flush, e_fl);
   endtask

   task automatic clear_inputs();
      id_src_a = '0; id_src_b = '0; ex_src_a = '0; ex_src_b = '0;
      ex_dst = '0; mem_dst = '0; wb_dst = '0;
      id_is_branch = 0; id_br_taken = 0; ex_wr = 0; ex_is_load = 0;
      mem_wr = 0; mem_is_load = 0; wb_wr = 0; br_policy = 2'b00;
   endtask

   // Inputs change just after the rising edge; outputs are compared at the falling edge.
   task automatic step();
      @(negedge clk);
      compare_all();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

   initial begin
      clear_inputs();
      @(posedge clk); #1;
      // R10: idle state, everything quiet
      step();

      // R1: both producers match, memory stage wins; operand B from writeback only
      clear_inputs();
      ex_src_a = 5'd7; ex_src_b = 5'd9;
      mem_dst = 5'd7; mem_wr = 1; wb_dst = 5'd7; wb_wr = 1;
      step();
      wb_dst = 5'd9; step();
      // R2: write flag low, and destination zero
      mem_wr = 0; wb_wr = 0; step();
      clear_inputs(); ex_src_a = 0; mem_dst = 0; mem_wr = 1; wb_dst = 0; wb_wr = 1; step();

      // R3: load-use on source B, with a taken branch in predict mode (R9)
      clear_inputs();
      id_src_b = 5'd4; ex_dst = 5'd4; ex_wr = 1; ex_is_load = 1; step();
      id_is_branch = 1; id_br_taken = 1; br_policy = 2'b01; step();
      // R3: load into register 0 does not stall
      ex_dst = 0; id_src_b = 0; id_is_branch = 0; step();

      // R4: branch depends on ALU result in execute, taken, hold policy (R9)
      clear_inputs();
      id_is_branch = 1; id_br_taken = 1; id_src_a = 5'd3; ex_dst = 5'd3; ex_wr = 1; step();
      // R4: load in memory stage feeding a branch
      clear_inputs();
      id_is_branch = 1; id_src_a = 5'd6; mem_dst = 5'd6; mem_wr = 1; mem_is_load = 1; step();
      // R5: same ALU producer in memory stage is bypassed to the comparator
      mem_is_load = 0; step();
      wb_dst = 5'd6; wb_wr = 1; mem_wr = 0; step();

      // R6 / R7 / R8: resolved branch under each policy, taken and not
      for (int p = 0; p < 4; p++) begin
         for (int t = 0; t < 2; t++) begin
            clear_inputs();
            id_is_branch = 1; id_br_taken = t[0]; br_policy = p[1:0];
            id_src_a = 5'd1; id_src_b = 5'd2;
            step();
         end
      end

      // Random phase with a tight register range to force collisions
      for (int n = 0; n < 3000; n++) begin
         id_src_a = AW'($urandom_range(0, 3)); id_src_b = AW'($urandom_range(0, 3));
         ex_src_a = AW'($urandom_range(0, 3)); ex_src_b = AW'($urandom_range(0, 3));
         ex_dst = AW'($urandom_range(0, 3)); mem_dst = AW'($urandom_range(0, 3));
         wb_dst = AW'($urandom_range(0, 3));
         id_is_branch = 1'($urandom_range(0, 1)); id_br_taken = 1'($urandom_range(0, 1));
         ex_wr = 1'($urandom_range(0, 1)); ex_is_load = 1'($urandom_range(0, 1));
         mem_wr = 1'($urandom_range(0, 1)); mem_is_load = 1'($urandom_range(0, 1));
         wb_wr = 1'($urandom_range(0, 1)); br_policy = 2'($urandom_range(0, 3));
         step();
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end
endmodule